// File: doc/BRIEF.md
# I2C Slave Byte Buffer and Flow Control

This block is the byte-level data path of an I2C target device. It sits between a bit-level shifter, which reports finished bytes and the start of each new byte as single-cycle pulses, and a CPU-side register interface. It holds one data register, a one-byte receive shift register and a transmit shift register. It maintains these flags: receive-not-empty, transmit-empty, byte-transfer-finished and address-matched. It also keeps two sticky error flags.

A configuration input picks one of two flow-control policies. With clock stretching allowed, the block pulls SCL low, through an active-high open-drain enable, whenever the CPU has fallen behind. It holds the line until the CPU reads or writes the data register. With stretching forbidden, the bus never waits. A byte that arrives while the data register is still unread is dropped and flags an overrun. A byte that must be sent before the CPU has supplied one is sent again from the stale data register and flags an underrun.

Top module: `i2c_slv_bytebuf`

## Requirements
- R1: After reset, receive-not-empty, byte-transfer-finished, address-matched, overrun, underrun and `scl_hold` are 0, and transmit-empty is 1.
- R2: In receive direction (`cfg_dir_tx`=0), a byte-done pulse with receive-not-empty clear puts `rx_shift_data` into the data register (`cpu_rdata`) and sets receive-not-empty. A `cpu_rd` pulse clears it when no second byte is waiting.
- R3: In receive direction with stretching off, a byte-done pulse while receive-not-empty is set raises overrun. The new byte is discarded: `cpu_rdata` keeps the unread byte and receive-not-empty stays 1.
- R4: In receive direction with stretching on, a second byte is kept in the shift register and sets byte-transfer-finished, with no overrun. A `cpu_rd` then moves it into the data register, clears byte-transfer-finished and leaves receive-not-empty set.
- R5: In transmit direction, `cpu_wr` loads the data register and clears transmit-empty. A next-byte pulse copies the data register to `tx_shift_data` and sets transmit-empty.
- R6: In transmit direction with stretching off, a next-byte pulse while transmit-empty is set raises underrun, and `tx_shift_data` carries the previous data-register byte again.
- R7: In transmit direction with stretching on, a byte-done pulse while transmit-empty is set sets byte-transfer-finished. `scl_hold` then asserts, and it releases after a `cpu_wr`, which clears both transmit-empty and byte-transfer-finished.
- R8: An address-match pulse sets address-matched and `cpu_addr_clr` clears it. With stretching on, SCL is held while it is set. Clearing it in transmit direction with transmit-empty set sets byte-transfer-finished, so the hold lasts until the first write. With stretching off, a first byte not written before the next-byte pulse is an underrun.
- R9: `scl_hold` only starts asserting while `scl_low` is 1; a pending hold condition during SCL high leaves it 0.
- R10: Overrun and underrun are sticky. Each clears only on its own clear pulse (`clr_ovr`, `clr_udr`), and a CPU access does not clear them.
- R11: A `cpu_wr` while a byte is being shifted out leaves `tx_shift_data` unchanged and raises no error flag. The written byte is sent at the following next-byte pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stretch_en | input | 1 | 1 allows clock stretching |
| cfg_dir_tx | input | 1 | 1 transmit direction, 0 receive direction |
| ev_addr_match | input | 1 | Pulse: own address recognised |
| ev_byte_done | input | 1 | Pulse: shifter finished a byte |
| ev_next_clk | input | 1 | Pulse: first clock of the next byte arrived |
| scl_low | input | 1 | Synchronised SCL-low level |
| rx_shift_data | input | DW | Byte assembled by the shifter |
| tx_shift_data | output | DW | Byte handed to the shifter |
| cpu_rd | input | 1 | Pulse: CPU reads the data register |
| cpu_wr | input | 1 | Pulse: CPU writes the data register |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Receive data register contents |
| cpu_addr_clr | input | 1 | Pulse: CPU clears address-matched |
| clr_ovr | input | 1 | Pulse: clear overrun |
| clr_udr | input | 1 | Pulse: clear underrun |
| flag_rxne | output | 1 | Receive-not-empty |
| flag_txe | output | 1 | Transmit-empty |
| flag_btf | output | 1 | Byte-transfer-finished for the active direction |
| flag_addr | output | 1 | Address-matched |
| flag_ovr | output | 1 | Overrun (sticky) |
| flag_udr | output | 1 | Underrun (sticky) |
| scl_hold | output | 1 | Open-drain enable pulling SCL low |

## Verification
Every cycle, the assertions check four things. An error flag only rises from its legal cause under the no-stretch policy. Both error flags stay set until their own clear. A hold only begins during SCL low. The transmit shift byte never moves without a next-byte pulse. Only the directed scenarios show the data values: which byte is kept on overrun, which byte is resent on underrun, the ordering of the two buffered receive bytes, and the first-byte sequence around address clearing.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } xfer_dir_e;

endpackage

// File: rtl/i2c_slv_rx_path.sv
module i2c_slv_rx_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_rx,
    input  logic          stretch_en,
    input  logic          byte_done,
    input  logic [DW-1:0] shift_in,
    input  logic          cpu_rd,
    input  logic          clr_ovr,
    output logic [DW-1:0] data_reg,
    output logic          rxne,
    output logic          btf,
    output logic          ovr
);

    typedef struct packed {
        logic [DW-1:0] dreg;
        logic [DW-1:0] sreg;
        logic          sreg_full;
        logic          rxne;
        logic          ovr;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // CPU read first: frees the data register or pulls the waiting byte up
        if (cpu_rd) begin
            if (st_q.sreg_full) begin
                st_d.dreg      = st_q.sreg;
                st_d.sreg_full = 1'b0;
            end else begin
                st_d.rxne = 1'b0;
            end
        end
        if (clr_ovr) begin
            st_d.ovr = 1'b0;
        end
        if (byte_done && en_rx) begin
            if (!st_d.rxne) begin
                st_d.dreg = shift_in;
                st_d.rxne = 1'b1;
            end else if (stretch_en && !st_d.sreg_full) begin
                st_d.sreg      = shift_in;
                st_d.sreg_full = 1'b1;
            end else if (!stretch_en) begin
                st_d.ovr = 1'b1;  // new byte dropped, unread byte kept
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_reg = st_q.dreg;
    assign rxne     = st_q.rxne;
    assign btf      = st_q.sreg_full;
    assign ovr      = st_q.ovr;

endmodule

// File: rtl/i2c_slv_tx_path.sv
module i2c_slv_tx_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_tx,
    input  logic          stretch_en,
    input  logic          next_clk,
    input  logic          byte_done,
    input  logic          addr_clr,
    input  logic          cpu_wr,
    input  logic [DW-1:0] wdata,
    input  logic          clr_udr,
    output logic [DW-1:0] shift_out,
    output logic          txe,
    output logic          btf,
    output logic          udr
);

    typedef struct packed {
        logic [DW-1:0] dreg;
        logic [DW-1:0] sreg;
        logic          txe;
        logic          btf;
        logic          udr;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_udr) begin
            st_d.udr = 1'b0;
        end
        if (en_tx) begin
            if (next_clk) begin
                // the shifter takes whatever sits in the data register
                st_d.sreg = st_q.dreg;
                if (st_q.txe && !stretch_en) begin
                    st_d.udr = 1'b1;
                end
                st_d.txe = 1'b1;
                st_d.btf = 1'b0;
            end
            if (byte_done && st_q.txe) begin
                st_d.btf = 1'b1;
            end
            if (addr_clr) begin
                st_d.btf = st_q.txe;
            end
        end
        if (cpu_wr) begin
            st_d.dreg = wdata;
            st_d.txe  = 1'b0;
            st_d.btf  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.txe <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_out = st_q.sreg;
    assign txe       = st_q.txe;
    assign btf       = st_q.btf;
    assign udr       = st_q.udr;

endmodule

// File: rtl/i2c_slv_hold_ctrl.sv
module i2c_slv_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic stretch_en,
    input  logic dir_tx,
    input  logic scl_low,
    input  logic addr_flag,
    input  logic txe,
    input  logic tx_btf,
    input  logic rxne,
    input  logic rx_btf,
    output logic hold
);

    typedef struct packed {
        logic hold;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic        need_wait;

    always_comb begin
        need_wait = addr_flag | (dir_tx ? (txe & tx_btf) : (rxne & rx_btf));
        st_d      = st_q;
        // start only in the low phase; once holding, the line stays low
        st_d.hold = stretch_en & need_wait & (scl_low | st_q.hold);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold = st_q.hold;

endmodule

// File: rtl/i2c_slv_bytebuf.sv
module i2c_slv_bytebuf
    import i2c_slv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_stretch_en,
    input  logic          cfg_dir_tx,
    input  logic          ev_addr_match,
    input  logic          ev_byte_done,
    input  logic          ev_next_clk,
    input  logic          scl_low,
    input  logic [DW-1:0] rx_shift_data,
    output logic [DW-1:0] tx_shift_data,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          cpu_addr_clr,
    input  logic          clr_ovr,
    input  logic          clr_udr,
    output logic          flag_rxne,
    output logic          flag_txe,
    output logic          flag_btf,
    output logic          flag_addr,
    output logic          flag_ovr,
    output logic          flag_udr,
    output logic          scl_hold
);

    typedef struct packed {
        logic addr;
    } top_state_t;

    top_state_t st_d, st_q;
    xfer_dir_e  dir;
    logic       is_tx;
    logic       rx_btf, tx_btf;

    assign dir   = xfer_dir_e'(cfg_dir_tx);
    assign is_tx = (dir == DIR_TX);

    always_comb begin
        st_d = st_q;
        if (cpu_addr_clr) begin
            st_d.addr = 1'b0;
        end
        if (ev_addr_match) begin
            st_d.addr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    i2c_slv_rx_path #(.DW(DW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_rx      (!is_tx),
        .stretch_en (cfg_stretch_en),
        .byte_done  (ev_byte_done),
        .shift_in   (rx_shift_data),
        .cpu_rd     (cpu_rd),
        .clr_ovr    (clr_ovr),
        .data_reg   (cpu_rdata),
        .rxne       (flag_rxne),
        .btf        (rx_btf),
        .ovr        (flag_ovr)
    );

    i2c_slv_tx_path #(.DW(DW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_tx      (is_tx),
        .stretch_en (cfg_stretch_en),
        .next_clk   (ev_next_clk),
        .byte_done  (ev_byte_done),
        .addr_clr   (cpu_addr_clr),
        .cpu_wr     (cpu_wr),
        .wdata      (cpu_wdata),
        .clr_udr    (clr_udr),
        .shift_out  (tx_shift_data),
        .txe        (flag_txe),
        .btf        (tx_btf),
        .udr        (flag_udr)
    );

    i2c_slv_hold_ctrl u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .stretch_en (cfg_stretch_en),
        .dir_tx     (is_tx),
        .scl_low    (scl_low),
        .addr_flag  (st_q.addr),
        .txe        (flag_txe),
        .tx_btf     (tx_btf),
        .rxne       (flag_rxne),
        .rx_btf     (rx_btf),
        .hold       (scl_hold)
    );

    assign flag_addr = st_q.addr;
    assign flag_btf  = is_tx ? tx_btf : rx_btf;

endmodule

// File: rtl/i2c_slv_bytebuf_chk.sv
module i2c_slv_bytebuf_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_stretch_en,
    input logic          ev_byte_done,
    input logic          ev_next_clk,
    input logic          scl_low,
    input logic [DW-1:0] tx_shift_data,
    input logic          clr_ovr,
    input logic          clr_udr,
    input logic          flag_txe,
    input logic          flag_ovr,
    input logic          flag_udr,
    input logic          scl_hold
);

    assert_ovr_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ovr) |-> $past(ev_byte_done && !cfg_stretch_en));

    assert_udr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_udr) |-> $past(ev_next_clk && flag_txe && !cfg_stretch_en));

    assert_hold_low_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> $past(scl_low));

    assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ovr && !clr_ovr) |=> flag_ovr);

    assert_udr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_udr && !clr_udr) |=> flag_udr);

    assert_shift_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_next_clk |=> $stable(tx_shift_data));

endmodule

bind i2c_slv_bytebuf i2c_slv_bytebuf_chk #(.DW(DW)) u_chk (.*);

// File: tb/i2c_slv_bytebuf_bench.sv
module i2c_slv_bytebuf_bench;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_stretch_en = 1'b0;
    logic          cfg_dir_tx = 1'b0;
    logic          ev_addr_match = 1'b0;
    logic          ev_byte_done = 1'b0;
    logic          ev_next_clk = 1'b0;
    logic          scl_low = 1'b0;
    logic [DW-1:0] rx_shift_data = '0;
    logic [DW-1:0] tx_shift_data;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_addr_clr = 1'b0;
    logic          clr_ovr = 1'b0;
    logic          clr_udr = 1'b0;
    logic          flag_rxne, flag_txe, flag_btf, flag_addr, flag_ovr, flag_udr, scl_hold;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    i2c_slv_bytebuf #(.DW(DW)) u_i2c_slv_bytebuf (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // drive a one-cycle pulse at a falling edge; returns after the capturing edge
    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic rx_byte(input logic [DW-1:0] b);
        rx_shift_data = b;
        pulse(ev_byte_done);
    endtask

    task automatic cpu_write(input logic [DW-1:0] b);
        cpu_wdata = b;
        pulse(cpu_wr);
    endtask

    task automatic test_reset();
        chk("R1", "rxne", flag_rxne, 1'b0);
        chk("R1", "txe", flag_txe, 1'b1);
        chk("R1", "btf", flag_btf, 1'b0);
        chk("R1", "addr", flag_addr, 1'b0);
        chk("R1", "ovr", flag_ovr, 1'b0);
        chk("R1", "udr", flag_udr, 1'b0);
        chk("R1", "hold", scl_hold, 1'b0);
    endtask

    task automatic test_rx_basic();
        cfg_dir_tx = 1'b0; cfg_stretch_en = 1'b0;
        rx_byte(8'hA5);
        chk("R2", "rdata", cpu_rdata, 8'hA5);
        chk("R2", "rxne set", flag_rxne, 1'b1);
        pulse(cpu_rd);
        chk("R2", "rxne cleared", flag_rxne, 1'b0);
    endtask

    task automatic test_overrun();
        cfg_dir_tx = 1'b0; cfg_stretch_en = 1'b0;
        rx_byte(8'h11);
        rx_byte(8'h22);
        chk("R3", "ovr", flag_ovr, 1'b1);
        chk("R3", "rdata kept", cpu_rdata, 8'h11);
        chk("R3", "rxne", flag_rxne, 1'b1);
        pulse(cpu_rd);
        chk("R10", "ovr after read", flag_ovr, 1'b1);
        pulse(clr_udr);
        chk("R10", "ovr after udr clear", flag_ovr, 1'b1);
        pulse(clr_ovr);
        chk("R10", "ovr cleared", flag_ovr, 1'b0);
    endtask

    task automatic test_rx_stretch();
        cfg_dir_tx = 1'b0; cfg_stretch_en = 1'b1; scl_low = 1'b0;
        rx_byte(8'h33);
        rx_byte(8'h44);
        chk("R4", "btf", flag_btf, 1'b1);
        chk("R4", "no ovr", flag_ovr, 1'b0);
        chk("R4", "rdata first", cpu_rdata, 8'h33);
        step();
        chk("R9", "no hold while scl high", scl_hold, 1'b0);
        scl_low = 1'b1;
        step();
        chk("R4", "hold asserted", scl_hold, 1'b1);
        pulse(cpu_rd);
        chk("R4", "rdata second", cpu_rdata, 8'h44);
        chk("R4", "btf cleared", flag_btf, 1'b0);
        chk("R4", "rxne kept", flag_rxne, 1'b1);
        step();
        chk("R4", "hold released", scl_hold, 1'b0);
        pulse(cpu_rd);
        chk("R4", "rxne drained", flag_rxne, 1'b0);
        scl_low = 1'b0; cfg_stretch_en = 1'b0;
    endtask

    task automatic test_tx_basic();
        cfg_dir_tx = 1'b1; cfg_stretch_en = 1'b0;
        cpu_write(8'h5A);
        chk("R5", "txe cleared", flag_txe, 1'b0);
        pulse(ev_next_clk);
        chk("R5", "shift byte", tx_shift_data, 8'h5A);
        chk("R5", "txe set", flag_txe, 1'b1);
        chk("R5", "no udr", flag_udr, 1'b0);
    endtask

    task automatic test_underrun();
        cfg_dir_tx = 1'b1; cfg_stretch_en = 1'b0;
        pulse(ev_byte_done);
        pulse(ev_next_clk);
        chk("R6", "udr", flag_udr, 1'b1);
        chk("R6", "stale byte resent", tx_shift_data, 8'h5A);
        cpu_write(8'h99);
        chk("R10", "udr after write", flag_udr, 1'b1);
        pulse(clr_ovr);
        chk("R10", "udr after ovr clear", flag_udr, 1'b1);
        pulse(clr_udr);
        chk("R10", "udr cleared", flag_udr, 1'b0);
        pulse(ev_next_clk);
        chk("R5", "second byte", tx_shift_data, 8'h99);
    endtask

    task automatic test_tx_stretch();
        cfg_dir_tx = 1'b1; cfg_stretch_en = 1'b1; scl_low = 1'b1;
        pulse(ev_byte_done);
        chk("R7", "btf", flag_btf, 1'b1);
        step();
        chk("R7", "hold", scl_hold, 1'b1);
        cpu_write(8'h66);
        chk("R7", "txe cleared", flag_txe, 1'b0);
        chk("R7", "btf cleared", flag_btf, 1'b0);
        step();
        chk("R7", "hold released", scl_hold, 1'b0);
        pulse(ev_next_clk);
        chk("R7", "shift byte", tx_shift_data, 8'h66);
        chk("R7", "no udr", flag_udr, 1'b0);
    endtask

    task automatic test_first_byte();
        cfg_dir_tx = 1'b1; cfg_stretch_en = 1'b1; scl_low = 1'b1;
        pulse(ev_addr_match);
        chk("R8", "addr set", flag_addr, 1'b1);
        step();
        chk("R8", "hold on addr", scl_hold, 1'b1);
        pulse(cpu_addr_clr);
        chk("R8", "addr cleared", flag_addr, 1'b0);
        chk("R8", "btf after addr clear", flag_btf, 1'b1);
        step();
        chk("R8", "hold until write", scl_hold, 1'b1);
        cpu_write(8'h77);
        step();
        chk("R8", "hold released", scl_hold, 1'b0);
        cfg_stretch_en = 1'b0;
        pulse(ev_next_clk);
        pulse(ev_byte_done);
        pulse(ev_addr_match);
        pulse(cpu_addr_clr);
        pulse(ev_next_clk);
        chk("R8", "late first byte underrun", flag_udr, 1'b1);
        chk("R8", "stale first byte", tx_shift_data, 8'h77);
        pulse(clr_udr);
        scl_low = 1'b0;
    endtask

    task automatic test_collision();
        cfg_dir_tx = 1'b1; cfg_stretch_en = 1'b0;
        cpu_write(8'h12);
        pulse(ev_next_clk);
        chk("R11", "first byte", tx_shift_data, 8'h12);
        cpu_write(8'h34);
        chk("R11", "shift unchanged", tx_shift_data, 8'h12);
        chk("R11", "no ovr", flag_ovr, 1'b0);
        chk("R11", "no udr", flag_udr, 1'b0);
        pulse(ev_byte_done);
        pulse(ev_next_clk);
        chk("R11", "written byte sent next", tx_shift_data, 8'h34);
        chk("R11", "no udr after", flag_udr, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) step();
        rst_n = 1'b1;
        step();
        test_reset();
        test_rx_basic();
        test_overrun();
        test_rx_stretch();
        test_tx_basic();
        test_underrun();
        test_tx_stretch();
        test_first_byte();
        test_collision();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule